// File: doc/BRIEF.md
# TLB Address Translation Unit

This block maps 16-bit virtual addresses to physical addresses through a small fully associative translation cache of page-to-frame mappings. A requester raises a translate request and holds it until the block answers. The answer is either a physical address or a fault indication. The upper bits of the address select a virtual page. The lower bits pass through unchanged as the offset within the page.

On a hit, the answer comes back in the cycle of the request. On a miss, the block walks a page-table memory port with a one-cycle-latency request/valid handshake. If it has to evict a live entry, it first writes that entry's modify bit back to the page table. It then reads the entry for the missing page and installs it. The held request then hits.

A page-table entry marked absent produces a fault answer and installs nothing. A context-switch pulse invalidates every cached entry. Each cached entry also keeps a reference bit and a modify bit, which are updated as accesses occur.

Top module: `tlb_xlate`

## Requirements
- R1: After reset `busy`, `resp_valid` and `pt_req_valid` are low, and every cached entry is invalid, so the first access to any page misses.
- R2: A virtual address splits into a 4-bit page number (bits 15:12) and a 12-bit offset (bits 11:0). A successful translation returns `{frame, offset}`, where the frame comes from the page-table entry of that page.
- R3: A request whose page is cached is answered in the same cycle with `resp_valid` high, `resp_fault` low and no page-table traffic.
- R4: On a miss, the block issues one page-table read for the requested page. It raises `busy` until it answers. When no write-back is needed, the answer arrives 3 cycles after the request is first presented. A page-table entry is 7 bits: bit 6 present, bit 5 modify, bit 4 reference, bits 3:0 frame.
- R5: The entry replaced on a miss is the lowest-numbered invalid entry. When all 8 entries are valid, it is the entry under a round-robin pointer. The pointer starts at 0 after reset and steps by one, wrapping from 7 to 0, each time it is used.
- R6: Evicting a valid entry first issues a page-table write carrying the evicted page number and its modify bit. The refill read follows that write, and the answer arrives 5 cycles after the request is first presented.
- R7: When the fetched entry has its present bit clear, the block answers with `resp_fault` high and installs nothing, so a repeated access to that page faults again.
- R8: An installed entry takes its modify and reference bits from the page-table entry. A write access sets the cached modify bit, and a read leaves it unchanged. Any access sets the reference bit.
- R9: A one-cycle `ctx_switch` pulse invalidates all cached entries, so the next access to any page misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_switch | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translate request, held until `resp_valid` |
| req_write | input | 1 | Request is a write access |
| req_vaddr | input | 16 | Virtual address |
| resp_valid | output | 1 | Answer for the held request |
| resp_fault | output | 1 | Answer is a page fault |
| resp_paddr | output | 16 | Physical address |
| busy | output | 1 | Miss handling in progress |
| pt_req_valid | output | 1 | Page-table request |
| pt_req_write | output | 1 | Request writes the modify bit back |
| pt_req_vpn | output | 4 | Page-table index |
| pt_req_modify | output | 1 | Modify bit to store on a write |
| pt_rsp_valid | input | 1 | Page-table answer, one cycle after the request |
| pt_rsp_data | input | 7 | Page-table entry read |

## Verification
The assertions assume the following about the environment:
- The requester holds `req_valid`, the address and the write flag steady from the first cycle of a request until `resp_valid`.
- `ctx_switch` pulses only while no request is held.
- The page table answers each request exactly one cycle later.

The stimulus meets these assumptions by construction. Each access is driven from a task that changes the request inputs only after the answer has been observed. Context switches are issued only between accesses, with `req_valid` low. The bench memory model answers every request on the following edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W = 4;
  localparam int OFF_W = 12;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PFN_W = 4;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int PTE_W = PFN_W + 3;

  typedef struct packed {
    logic             present;
    logic             modify;
    logic             refd;
    logic [PFN_W-1:0] pfn;
  } pte_t;

  function automatic logic [VPN_W-1:0] va_page(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] va_offset(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lookup_vpn,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PFN_W-1:0] hit_pfn,
  input  logic             access_en,
  input  logic             access_write,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  pte_t             fill_pte,
  input  logic             rr_adv,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_valid,
  output logic [VPN_W-1:0] victim_vpn,
  output logic             victim_mod
);
  logic [ENTRIES-1:0] valid_q, refd_q, mod_q, match;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign match[i] = valid_q[i] && (vpn_q[i] == lookup_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_idx = IDX_W'(i);
  end
  assign hit     = |match;
  assign hit_pfn = pfn_q[hit_idx];

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = rr_q;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !valid_q[i]) begin
        found      = 1'b1;
        victim_idx = IDX_W'(i);
      end
  end
  assign victim_valid = &valid_q;
  assign victim_vpn   = vpn_q[victim_idx];
  assign victim_mod   = mod_q[victim_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      refd_q  <= '0;
      mod_q   <= '0;
      rr_q    <= '0;
    end else begin
      if (rr_adv)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      if (flush) begin
        valid_q <= '0;
      end else if (fill_en) begin
        valid_q[fill_idx] <= 1'b1;
        refd_q[fill_idx]  <= fill_pte.refd;
        mod_q[fill_idx]   <= fill_pte.modify;
      end else if (access_en) begin
        refd_q[hit_idx] <= 1'b1;
        if (access_write) mod_q[hit_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      vpn_q[fill_idx] <= fill_vpn;
      pfn_q[fill_idx] <= fill_pte.pfn;
    end
  end

  assert_unique_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
  assert_victim_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_valid && !flush) |-> (victim_idx == rr_q));
  assert_ref_on_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (access_en && !flush && !fill_en) |=> refd_q[$past(hit_idx)]);
  assert_mod_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (access_en && access_write && !flush && !fill_en) |=> mod_q[$past(hit_idx)]);
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             hit,
  input  logic [IDX_W-1:0] victim_idx,
  input  logic             victim_valid,
  input  logic [VPN_W-1:0] victim_vpn,
  input  logic             victim_mod,
  input  logic             pt_rsp_valid,
  input  logic [PTE_W-1:0] pt_rsp_data,
  output logic             idle,
  output logic             fault_resp,
  output logic             rr_adv,
  output logic             fill_en,
  output logic [IDX_W-1:0] fill_idx,
  output logic [VPN_W-1:0] fill_vpn,
  output pte_t             fill_pte,
  output logic             pt_req_valid,
  output logic             pt_req_write,
  output logic [VPN_W-1:0] pt_req_vpn,
  output logic             pt_req_modify
);
  typedef enum logic [2:0] {S_IDLE, S_WB, S_WBW, S_RD, S_RDW, S_FLT} wstate_e;

  wstate_e          state_q, state_d;
  logic [VPN_W-1:0] miss_vpn_q, vic_vpn_q;
  logic [IDX_W-1:0] vic_idx_q;
  logic             vic_mod_q;
  logic             miss_start;
  pte_t             rsp_pte;

  assign rsp_pte    = pte_t'(pt_rsp_data);
  assign idle       = (state_q == S_IDLE);
  assign miss_start = idle && req_valid && !hit;
  assign rr_adv     = miss_start && victim_valid;
  assign fault_resp = (state_q == S_FLT);

  assign pt_req_valid  = (state_q == S_WB) || (state_q == S_RD);
  assign pt_req_write  = (state_q == S_WB);
  assign pt_req_vpn    = (state_q == S_WB) ? vic_vpn_q : miss_vpn_q;
  assign pt_req_modify = (state_q == S_WB) && vic_mod_q;

  assign fill_en  = (state_q == S_RDW) && pt_rsp_valid && rsp_pte.present;
  assign fill_idx = vic_idx_q;
  assign fill_vpn = miss_vpn_q;
  assign fill_pte = rsp_pte;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (miss_start) state_d = victim_valid ? S_WB : S_RD;
      S_WB:   state_d = S_WBW;
      S_WBW:  if (pt_rsp_valid) state_d = S_RD;
      S_RD:   state_d = S_RDW;
      S_RDW:  if (pt_rsp_valid) state_d = rsp_pte.present ? S_IDLE : S_FLT;
      S_FLT:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      miss_vpn_q <= '0;
      vic_vpn_q  <= '0;
      vic_idx_q  <= '0;
      vic_mod_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (miss_start) begin
        miss_vpn_q <= req_vpn;
        vic_idx_q  <= victim_idx;
        vic_vpn_q  <= victim_vpn;
        vic_mod_q  <= victim_mod;
      end
    end
  end

  assert_single_pt_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req_valid |=> !pt_req_valid);
  assert_read_after_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WBW && pt_rsp_valid) |=>
      (pt_req_valid && !pt_req_write && pt_req_vpn == $past(miss_vpn_q)));
  assert_wb_only_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start && !victim_valid) |=> (state_q == S_RD));
  assert_fault_no_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_resp |-> !fill_en);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctx_switch,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             resp_valid,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             busy,
  output logic             pt_req_valid,
  output logic             pt_req_write,
  output logic [VPN_W-1:0] pt_req_vpn,
  output logic             pt_req_modify,
  input  logic             pt_rsp_valid,
  input  logic [PTE_W-1:0] pt_rsp_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic             hit, idle, fault_resp, rr_adv, fill_en, victim_valid, victim_mod;
  logic             access_en, hit_resp;
  logic [IDX_W-1:0] hit_idx, fill_idx, victim_idx;
  logic [PFN_W-1:0] hit_pfn;
  logic [VPN_W-1:0] fill_vpn, victim_vpn, req_vpn;
  pte_t             fill_pte;

  assign req_vpn   = va_page(req_vaddr);
  assign hit_resp  = idle && req_valid && hit;
  assign access_en = hit_resp;

  tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk(clk), .rst_n(rst_n), .lookup_vpn(req_vpn),
    .hit(hit), .hit_idx(hit_idx), .hit_pfn(hit_pfn),
    .access_en(access_en), .access_write(req_write), .flush(ctx_switch),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
    .rr_adv(rr_adv), .victim_idx(victim_idx), .victim_valid(victim_valid),
    .victim_vpn(victim_vpn), .victim_mod(victim_mod)
  );

  tlb_walker #(.ENTRIES(ENTRIES)) u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn), .hit(hit),
    .victim_idx(victim_idx), .victim_valid(victim_valid), .victim_vpn(victim_vpn),
    .victim_mod(victim_mod), .pt_rsp_valid(pt_rsp_valid), .pt_rsp_data(pt_rsp_data),
    .idle(idle), .fault_resp(fault_resp), .rr_adv(rr_adv), .fill_en(fill_en),
    .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
    .pt_req_valid(pt_req_valid), .pt_req_write(pt_req_write),
    .pt_req_vpn(pt_req_vpn), .pt_req_modify(pt_req_modify)
  );

  assign resp_valid = hit_resp || fault_resp;
  assign resp_fault = fault_resp;
  assign resp_paddr = hit_resp ? join_pa(hit_pfn, va_offset(req_vaddr)) : '0;
  assign busy       = !idle;

  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_resp |-> (!pt_req_valid && !resp_fault));
  assert_fault_is_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> (resp_valid && busy));
  assert_miss_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idle && !hit && !ctx_switch) |=> busy);
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  import tlb_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctx_switch = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic resp_valid, resp_fault, busy;
  logic [15:0] resp_paddr;
  logic pt_req_valid, pt_req_write, pt_req_modify;
  logic [3:0] pt_req_vpn;
  logic pt_rsp_valid = 1'b0;
  logic [6:0] pt_rsp_data = '0;

  int checks = 0, errors = 0;
  logic [6:0] pt [16];

  logic       m_valid [8];
  logic [3:0] m_vpn   [8];
  logic       m_mod   [8];
  int         m_rr = 0;

  always #10 clk = ~clk;

  tlb_xlate u0 (
    .clk(clk), .rst_n(rst_n), .ctx_switch(ctx_switch), .req_valid(req_valid),
    .req_write(req_write), .req_vaddr(req_vaddr), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_paddr(resp_paddr), .busy(busy),
    .pt_req_valid(pt_req_valid), .pt_req_write(pt_req_write), .pt_req_vpn(pt_req_vpn),
    .pt_req_modify(pt_req_modify), .pt_rsp_valid(pt_rsp_valid), .pt_rsp_data(pt_rsp_data)
  );

  always @(posedge clk) begin
    pt_rsp_valid <= pt_req_valid;
    if (pt_req_valid && !pt_req_write) pt_rsp_data <= pt[pt_req_vpn];
    if (pt_req_valid && pt_req_write)  pt[pt_req_vpn][5] <= pt_req_modify;
  end

  function automatic logic [15:0] exp_pa(input logic [6:0] e, input logic [11:0] off);
    return {e[3:0], off};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
  endtask

  task automatic access(input logic [3:0] vpn, input logic [11:0] off, input logic wr);
    int hit_i = -1, vic = -1, lat = 0, exp_lat;
    bit exp_wb, saw_wb = 0, saw_rd = 0;
    logic [3:0] wb_vpn = '0;
    logic wb_mod = 1'b0;
    for (int i = 0; i < 8; i++) if (m_valid[i] && m_vpn[i] == vpn) hit_i = i;
    exp_wb = 0;
    if (hit_i < 0) begin
      for (int i = 7; i >= 0; i--) if (!m_valid[i]) vic = i;
      if (vic < 0) begin
        vic = m_rr; m_rr = (m_rr + 1) % 8;
        exp_wb = 1; wb_vpn = m_vpn[vic]; wb_mod = m_mod[vic];
      end
    end
    exp_lat = (hit_i >= 0) ? 0 : (exp_wb ? 5 : 3);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {vpn, off}; req_write = wr;
    #1;
    while (!resp_valid && lat < 20) begin
      if (pt_req_valid) begin
        if (pt_req_write) begin
          check(exp_wb && !saw_rd && pt_req_vpn == wb_vpn, "R6 wb vpn/order",
                pt_req_vpn, wb_vpn);
          check(pt_req_modify == wb_mod, "R6/R8 wb modify", pt_req_modify, wb_mod);
          saw_wb = 1;
        end else begin
          check(pt_req_vpn == vpn, "R4 read vpn", pt_req_vpn, vpn);
          saw_rd = 1;
        end
      end
      @(negedge clk); #1; lat++;
    end
    check(resp_valid, "R4 answer arrives", resp_valid, 1);
    check(lat == exp_lat, hit_i >= 0 ? "R3 hit latency" : (exp_wb ? "R6 latency" : "R4 latency"),
          lat, exp_lat);
    check(saw_wb == exp_wb, "R6 write-back issued", saw_wb, exp_wb);
    check(saw_rd == (hit_i < 0), "R3/R4 read issued", saw_rd, hit_i < 0);
    if (!pt[vpn][6] && hit_i < 0) begin
      check(resp_fault, "R7 fault", resp_fault, 1);
    end else begin
      check(!resp_fault, "R2 no fault", resp_fault, 0);
      check(resp_paddr == exp_pa(pt[vpn], off), "R2 paddr", resp_paddr,
            exp_pa(pt[vpn], off));
      if (hit_i < 0) begin
        m_valid[vic] = 1'b1; m_vpn[vic] = vpn; m_mod[vic] = pt[vpn][5]; hit_i = vic;
      end
      m_mod[hit_i] = m_mod[hit_i] | wr;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_ctx();
    @(negedge clk); ctx_switch = 1'b1;
    @(negedge clk); ctx_switch = 1'b0;
    model_flush();
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int v = 0; v < 16; v++)
      pt[v] = {(v != 3 && v != 12), 1'b0, 1'b0, 4'(v ^ 4'hA)};
    pt[5][5] = 1'b1;
    model_flush();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(!busy, "R1 busy low", busy, 0);
    check(!resp_valid, "R1 resp low", resp_valid, 0);
    check(!pt_req_valid, "R1 pt idle", pt_req_valid, 0);
    access(4'd1, 12'h123, 1'b0);   // R1 R4: first access misses
    access(4'd1, 12'hABC, 1'b1);   // R3 hit, R8 write sets modify
    access(4'd3, 12'h010, 1'b0);   // R7 fault
    access(4'd3, 12'h010, 1'b0);   // R7 not installed
    for (int v = 4; v < 11; v++) access(4'(v), 12'(v * 7), 1'b0); // R5 fill free slots
    access(4'd13, 12'hFFF, 1'b0);  // R5 R6 evict entry 0 (page 1, dirty)
    access(4'd14, 12'h000, 1'b1);  // R5 evict entry 1
    access(4'd1, 12'h001, 1'b0);   // R8 page 1 refilled with stored modify
    pulse_ctx();
    access(4'd13, 12'h055, 1'b0);  // R9 misses after switch
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 24) == 0) pulse_ctx();
      access(4'($urandom_range(0, 15)), 12'($urandom), 1'($urandom_range(0, 1)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule